// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from a network controller's transmit, receive and timer logic into a set of sticky status bits. A mask register selects which of those bits may drive a single registered interrupt line toward the host. The host reads the status to find which source fired. It then clears the bits it has handled by writing ones to them.

Two sources are produced inside the block. The first is a free-running down-counting general-purpose timer that raises its status bit when it wraps from zero to all ones. The host can load and read this timer through the same register port. The second is a transmit-error flag, raised when a packet completes with any of several distinct failure causes. All other sources arrive as pulses on an event input vector. The register port is a simple single-cycle write strobe with an address, and read data is a combinational function of the address.

Top module: `irq_hub`

## Requirements
- R1: While reset is asserted, all status bits and all mask bits are 0, the interrupt output is 0 and the timer holds all ones.
- R2: A 1 on an event input bit sets the matching status bit on the next clock edge, and the bit stays set until the host clears it.
- R3: A write to the status address (1) clears every status bit whose write-data bit is 1; status bits written with 0 keep their value.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit is 1 afterwards.
- R5: A write to the mask address (0) loads the mask from the low write-data bits, with 1 enabling and 0 disabling a source; reading address 0 returns the mask.
- R6: The interrupt output is 1 in the cycle after any status bit and its mask bit are both 1, and 0 in the cycle after no such pair exists.
- R7: Status bit 8 is set when the transmit-done pulse is 1 and at least one transmit-error cause bit is 1 (cause bit 0 byte-count mismatch, bit 1 excessive collisions, bit 2 FIFO underrun). A transmit-done pulse with no cause bit set leaves bit 8 unchanged.
- R8: The timer decrements by one each clock. A write to the timer address (2) loads it with the write data in place of the decrement. Reading address 2 returns the current count.
- R9: When the timer is 0 and not being loaded, the next edge sets it to all ones and sets status bit 7.
- R10: Event input bits 7 and 8 have no effect, because those status bits belong to the timer and the transmit-error sources.
- R11: Reading address 3 returns 0, and writes to address 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_i | input | 16 | Event pulses, one per status bit (bits 7 and 8 unused) |
| tx_done_i | input | 1 | Packet transmission finished |
| tx_cause_i | input | 3 | Transmit error causes, valid with tx_done_i |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 mask, 1 status, 2 timer, 3 unused |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A status bit that is wrongly dropped or wrongly set shows up on the status read path in the very next cycle. If its mask bit is on, the interrupt line also changes one cycle after that. A timer that is off by a count shows at once on the timer read. It also moves the rollover status bit by that many cycles, so loading small timer values exposes a counting fault within a few dozen cycles. Random stimulus compares the read data and the interrupt line against a bench model every cycle. The same-cycle set and clear collision, the transmit-done pulse with no cause, and the timer wrap are each driven on purpose.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Register address map of the host port
  typedef enum logic [1:0] {
    ADDR_MASK  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_TIMER = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  // Source positions with a fixed meaning
  localparam int unsigned TMR_SRC_BIT   = 7;
  localparam int unsigned TXERR_SRC_BIT = 8;

endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         roll_o
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    roll_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (at_zero) begin
      cnt_d  = ALL_ONES;
      roll_o = 1'b1;
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ALL_ONES;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R8
  tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

  // R8
  tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R9
  tmr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == ALL_ONES));

endmodule

// File: rtl/irq_txerr_agg.sv
module irq_txerr_agg #(
  parameter int unsigned NUM_CAUSE = 3
) (
  input  logic                 tx_done_i,
  input  logic [NUM_CAUSE-1:0] cause_i,
  output logic                 err_o
);

  logic any_cause;

  always_comb begin
    any_cause = 1'b0;
    for (int k = 0; k < NUM_CAUSE; k++) begin
      any_cause = any_cause | cause_i[k];
    end
    err_o = tx_done_i & any_cause;
  end

endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] st_o
);

  logic [N-1:0] st_q;
  logic [N-1:0] st_d;
  logic [N-1:0] st_en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      st_en[i] = src_i[i] | clr_i[i];
      st_d[i]  = src_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= 1'b0;
      end else if (st_en[i]) begin
        st_q[i] <= st_d[i];
      end
    end

    // R2
    st_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_i[i] |=> st_q[i]);

    // R2
    st_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] && !clr_i[i]) |=> st_q[i]);

    // R3
    st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !src_i[i]) |=> !st_q[i]);

    // R4
    st_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && src_i[i]) |=> st_q[i]);

    // R2
    st_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q[i] && !src_i[i]) |=> !st_q[i]);
  end

  assign st_o = st_q;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);

  logic [N-1:0] mask_q;
  logic [N-1:0] mask_d;

  always_comb begin
    mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (we_i) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_q));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_q == $past(wdata_i)));

endmodule

// File: rtl/irq_out.sv
module irq_out #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] st_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);

  logic pend;
  logic irq_q;

  always_comb begin
    pend = |(st_i & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= pend;
    end
  end

  assign irq_o = irq_q;

  // R6
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_i & mask_i)) |=> irq_o);

  // R6
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(st_i & mask_i)) |=> !irq_o);

endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned NUM_SRC   = 16,
  parameter int unsigned NUM_CAUSE = 3,
  parameter int unsigned DW        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   evt_i,
  input  logic                 tx_done_i,
  input  logic [NUM_CAUSE-1:0] tx_cause_i,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  output logic                 irq_o
);

  import irq_pkg::*;

  localparam int unsigned PAD_W = DW - NUM_SRC;

  logic [NUM_SRC-1:0] src;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] st;
  logic [NUM_SRC-1:0] mask;
  logic [DW-1:0]      tmr_cnt;
  logic               tmr_roll;
  logic               tx_err;
  logic               we_mask;
  logic               we_stat;
  logic               we_tmr;

  // Write decode
  always_comb begin
    we_mask = reg_we_i && (reg_addr_i == ADDR_MASK);
    we_stat = reg_we_i && (reg_addr_i == ADDR_STAT);
    we_tmr  = reg_we_i && (reg_addr_i == ADDR_TIMER);
    clr     = we_stat ? reg_wdata_i[NUM_SRC-1:0] : '0;
  end

  // Source vector: two positions come from internal sources
  always_comb begin
    src                = evt_i;
    src[TMR_SRC_BIT]   = tmr_roll;
    src[TXERR_SRC_BIT] = tx_err;
  end

  irq_timer #(.W(DW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (we_tmr),
    .load_val_i (reg_wdata_i),
    .cnt_o      (tmr_cnt),
    .roll_o     (tmr_roll)
  );

  irq_txerr_agg #(.NUM_CAUSE(NUM_CAUSE)) u_txerr (
    .tx_done_i (tx_done_i),
    .cause_i   (tx_cause_i),
    .err_o     (tx_err)
  );

  irq_status #(.N(NUM_SRC)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src),
    .clr_i (clr),
    .st_o  (st)
  );

  irq_mask_reg #(.N(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we_mask),
    .wdata_i (reg_wdata_i[NUM_SRC-1:0]),
    .mask_o  (mask)
  );

  irq_out #(.N(NUM_SRC)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .st_i   (st),
    .mask_i (mask),
    .irq_o  (irq_o)
  );

  // Read mux
  always_comb begin
    unique case (reg_addr_i)
      ADDR_MASK:  reg_rdata_o = {{PAD_W{1'b0}}, mask};
      ADDR_STAT:  reg_rdata_o = {{PAD_W{1'b0}}, st};
      ADDR_TIMER: reg_rdata_o = tmr_cnt;
      default:    reg_rdata_o = '0;
    endcase
  end

  // R9
  roll_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_roll |=> st[TMR_SRC_BIT]);

  // R10
  ext_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st[TMR_SRC_BIT] && !tmr_roll) |=> !st[TMR_SRC_BIT]);

  // R7
  txerr_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done_i && (|tx_cause_i)) |=> st[TXERR_SRC_BIT]);

  // R10
  ext_bit8_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st[TXERR_SRC_BIT] && !(tx_done_i && (|tx_cause_i))) |=> !st[TXERR_SRC_BIT]);

  // R11
  addr3_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_NONE) |-> (reg_rdata_o == '0));

endmodule

// File: tb/irq_hub_tb.sv
module irq_hub_tb_top;

  localparam int NS = 16;
  localparam int NC = 3;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] evt;
  logic          tx_done;
  logic [NC-1:0] tx_cause;
  logic          we;
  logic [1:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // bench model state
  logic [NS-1:0] m_st;
  logic [NS-1:0] m_mask;
  logic [DW-1:0] m_tmr;
  logic          m_irq;

  irq_hub dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .tx_done_i   (tx_done),
    .tx_cause_i  (tx_cause),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] read_model(input logic [1:0] a);
    case (a)
      2'd0: return {{(DW-NS){1'b0}}, m_mask};
      2'd1: return {{(DW-NS){1'b0}}, m_st};
      2'd2: return m_tmr;
      default: return '0;
    endcase
  endfunction

  // Advance one clock, update the model with the applied inputs, check ports.
  task automatic step();
    logic [NS-1:0] src;
    logic [NS-1:0] clr;
    logic          roll;
    @(posedge clk);
    m_irq = |(m_st & m_mask);
    roll  = 1'b0;
    if (we && addr == 2'd2) m_tmr = wdata;
    else if (m_tmr == '0) begin m_tmr = '1; roll = 1'b1; end
    else m_tmr = m_tmr - 1;
    src    = evt;
    src[7] = roll;
    src[8] = tx_done & (|tx_cause);
    clr    = (we && addr == 2'd1) ? wdata[NS-1:0] : '0;
    m_st   = (m_st & ~clr) | src;
    if (we && addr == 2'd0) m_mask = wdata[NS-1:0];
    #1;
    chk("R6 irq", {31'b0, irq}, {31'b0, m_irq});
    case (addr)
      2'd0: chk("R5 mask read", rdata, read_model(addr));
      2'd1: chk("R2/R3 status read", rdata, read_model(addr));
      2'd2: chk("R8 timer read", rdata, read_model(addr));
      default: chk("R11 addr3 read", rdata, read_model(addr));
    endcase
    evt = '0; tx_done = 1'b0; tx_cause = '0; we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; tx_done = 0; tx_cause = '0; we = 0; addr = 2'd0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    addr = 2'd0; #1; chk("R1 mask reset", rdata, '0);
    addr = 2'd1; #1; chk("R1 status reset", rdata, '0);
    addr = 2'd2; #1; chk("R1 timer reset", rdata, '1);
    chk("R1 irq reset", {31'b0, irq}, '0);
    m_st = '0; m_mask = '0; m_tmr = '1; m_irq = 0;
    rst_n = 1'b1;
    addr = 2'd1;

    // R2 event sets bit, sticky
    evt = 16'h0004; step();
    chk("R2 set", rdata, 32'h4);
    step(); chk("R2 sticky", rdata, 32'h4);
    // R3 clear with 0 no effect, clear with 1
    wr(2'd1, 32'h0000_0000); addr = 2'd1; #1; chk("R3 write0 keeps", rdata, 32'h4);
    wr(2'd1, 32'h0000_0004); addr = 2'd1; #1; chk("R3 write1 clears", rdata, 32'h0);
    // R4 collision
    evt = 16'h0008; wr(2'd1, 32'h0000_0008); addr = 2'd1; #1; chk("R4 set wins", rdata, 32'h8);
    // R5/R6 mask enables irq
    wr(2'd0, 32'h0000_0008); addr = 2'd0; #1; chk("R5 mask load", rdata, 32'h8);
    step(); chk("R6 irq high", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h0000_0008); step(); chk("R6 irq low after clear", {31'b0, irq}, 32'h0);
    // R7 transmit error
    tx_done = 1; tx_cause = 3'b000; addr = 2'd1; step();
    chk("R7 no cause no set", rdata, 32'h0);
    tx_done = 1; tx_cause = 3'b100; addr = 2'd1; step();
    chk("R7 underrun sets bit8", rdata, 32'h100);
    wr(2'd1, 32'h100);
    tx_done = 0; tx_cause = 3'b011; addr = 2'd1; step();
    chk("R7 cause without done", rdata, 32'h0);
    // R10 external bits 7 and 8 ignored
    evt = 16'h0180; addr = 2'd1; step();
    chk("R10 ext 7/8 ignored", rdata, 32'h0);
    // R9 timer wrap: load 2, then 2,1,0 then wrap
    wr(2'd2, 32'd2); addr = 2'd1;
    step(); step();
    chk("R9 not yet", rdata, 32'h0);
    step(); chk("R9 wrap sets bit7", rdata, 32'h80);
    addr = 2'd2; #1; chk("R9 wrap to all ones", rdata, 32'hFFFF_FFFF);
    // R11 address 3
    wr(2'd3, 32'hFFFF_FFFF); addr = 2'd3; #1; chk("R11 addr3 reads 0", rdata, 32'h0);
    addr = 2'd0; #1; chk("R11 addr3 write ignored", rdata, 32'h8);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 10;
      evt = (($urandom % 4) == 0) ? NS'($urandom) : '0;
      if (($urandom % 6) == 0) begin tx_done = 1; tx_cause = NC'($urandom); end
      if (r < 3) begin
        we = 1'b1; addr = 2'($urandom % 4);
        wdata = (addr == 2'd2) ? DW'($urandom % 20) : DW'($urandom);
      end else begin
        addr = 2'($urandom % 4);
      end
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule